// File: doc/BRIEF.md
# Lane-Split Adder with Padding Blanking

This block is a 32-bit combinational adder whose datapath can be divided at run time into one, two or four independent lanes. The lanes always sit in fixed power-of-two containers, so every lane bit maps to a fixed wire. Each lane carries a truncated meaningful field at the bottom of its container: 11 bits for the single 32-bit lane and for each 16-bit lane, and 5 bits for each 8-bit lane. Every bit above a lane's field is padding.

A blanking mask is derived from the mode. It clears the padding bits of both operands before the add and clears them again on the sum, so padding never leaks into a result. Carry never crosses from one lane's container into the next. For each lane, the carry out of its top meaningful bit is reported on a 4-bit vector.

Mode encoding: `2'b00` selects one 32-bit lane, `2'b01` selects two 16-bit lanes with containers at bits 15..0 and 31..16, and `2'b10` selects four 8-bit lanes with containers at 7..0, 15..8, 23..16 and 31..24. `2'b11` behaves exactly like `2'b00`.

Top module: `simd_blank_adder`

## Requirements
- R1: In mode 2'b00, sum[10:0] equals (a[10:0] + b[10:0]) modulo 2^11.
- R2: In mode 2'b01, sum[10:0] equals (a[10:0] + b[10:0]) mod 2^11, and sum[26:16] equals (a[26:16] + b[26:16]) mod 2^11.
- R3: In mode 2'b10, each lane n (0..3) has sum[8n+4:8n] equal to (a[8n+4:8n] + b[8n+4:8n]) mod 2^5.
- R4: Every padding bit of sum is 0 in every mode. In mode 2'b00 the padding bits are 31..11. In mode 2'b01 they are 15..11 and 31..27. In mode 2'b10 they are bits 7..5 of each byte.
- R5: carry_out[n] is the carry out of the top meaningful bit of lane n. Lane 0 sits at index 0, and lane indices rise with bit position.
- R6: Entries of carry_out with no active lane are 0: bits 3..1 in mode 2'b00, and bits 3..2 in mode 2'b01.
- R7: Mode 2'b11 gives the same sum and carry_out as mode 2'b00.
- R8: Operand padding bits have no effect. Two operand pairs that agree on every meaningful bit give the same sum and carry_out.
- R9: No carry crosses a lane boundary. With all operand bits set, each lane's result is its own all-ones field plus all-ones, wrapped at the field width, with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Lane split selector (00 one lane, 01 two lanes, 10 four lanes, 11 as 00) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sum | output | 32 | Blanked lane-wise sum |
| carry_out | output | 4 | Per-lane carry out of the top meaningful bit |

## Verification
The hardest case to reach from the ports is a carry that would cross into a padding bit or into the neighbouring lane. In such a case a wrong mask or a missing cut only shows when a lane overflows while the bits above it are set. The stimulus therefore fills the padding with random data and drives the low 5-bit lanes exhaustively, so every overflow pattern occurs. It also applies all-ones operands in every mode and repeats vectors with the padding flipped, which makes both leaks visible on sum and carry_out.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
    localparam int SEG_W    = 8;
    localparam int NSEG     = 4;
    localparam int DATA_W   = SEG_W * NSEG;
    localparam int WIDE_W   = 11;
    localparam int NARROW_W = 5;
    localparam int FW_BITS  = $clog2(DATA_W) + 1;

    typedef enum logic [1:0] {
        MODE_X32 = 2'b00,
        MODE_X16 = 2'b01,
        MODE_X8  = 2'b10,
        MODE_ALT = 2'b11
    } lane_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]  mask;
        logic [NSEG-1:0]    cut;
        logic [NSEG-1:0]    lane_start;
        logic [FW_BITS-1:0] field_w;
    } lane_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic [NSEG-1:0]   cout;
    } add_res_t;
endpackage

// File: rtl/lane_cfg_gen.sv
module lane_cfg_gen
    import simd_add_pkg::*;
(
    input  lane_mode_e mode,
    output lane_cfg_t  cfg
);
    lane_cfg_t cfg_d;

    always_comb begin
        int segs_per_lane;
        int fw;
        int off;
        cfg_d = '0;
        case (mode)
            MODE_X16: begin segs_per_lane = NSEG / 2; fw = WIDE_W;   end
            MODE_X8:  begin segs_per_lane = 1;        fw = NARROW_W; end
            default:  begin segs_per_lane = NSEG;     fw = WIDE_W;   end
        endcase
        cfg_d.field_w = FW_BITS'(fw);
        for (int k = 0; k < NSEG; k++) begin
            off = (k % segs_per_lane) * SEG_W;
            cfg_d.lane_start[k] = (off == 0);
            cfg_d.cut[k]        = (off == 0);
            for (int j = 0; j < SEG_W; j++) begin
                cfg_d.mask[k*SEG_W + j] = ((off + j) < fw);
            end
        end
    end

    assign cfg = cfg_d;
endmodule

// File: rtl/seg_adder.sv
module seg_adder
    import simd_add_pkg::*;
(
    input  logic [DATA_W-1:0] a_m,
    input  logic [DATA_W-1:0] b_m,
    input  logic [NSEG-1:0]   cut,
    output logic [DATA_W-1:0] raw
);
    logic [DATA_W-1:0] raw_d;

    always_comb begin
        logic [SEG_W:0] part;
        logic           carry;
        carry = 1'b0;
        raw_d = '0;
        for (int k = 0; k < NSEG; k++) begin
            part = {1'b0, a_m[k*SEG_W +: SEG_W]} + {1'b0, b_m[k*SEG_W +: SEG_W]}
                 + {{SEG_W{1'b0}}, (cut[k] ? 1'b0 : carry)};
            raw_d[k*SEG_W +: SEG_W] = part[SEG_W-1:0];
            carry = part[SEG_W];
        end
    end

    assign raw = raw_d;
endmodule

// File: rtl/carry_tap.sv
module carry_tap
    import simd_add_pkg::*;
(
    input  logic [DATA_W-1:0]  raw,
    input  logic [NSEG-1:0]    lane_start,
    input  logic [FW_BITS-1:0] field_w,
    output logic [NSEG-1:0]    cout
);
    logic [NSEG-1:0] cout_d;

    always_comb begin
        int lane;
        cout_d = '0;
        lane   = 0;
        for (int k = 0; k < NSEG; k++) begin
            if (lane_start[k]) begin
                for (int p = 0; p < DATA_W; p++) begin
                    if (p == k*SEG_W + int'(field_w)) begin
                        cout_d[lane] = raw[p];
                    end
                end
                lane = lane + 1;
            end
        end
    end

    assign cout = cout_d;
endmodule

// File: rtl/simd_blank_adder.sv
module simd_blank_adder
    import simd_add_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic [NSEG-1:0]   carry_out
);
    lane_cfg_t         cfg;
    logic [DATA_W-1:0] raw;
    logic [NSEG-1:0]   cout;
    add_res_t          res_d;

    lane_cfg_gen u_cfg (
        .mode (lane_mode_e'(mode)),
        .cfg  (cfg)
    );

    seg_adder u_add (
        .a_m (a & cfg.mask),
        .b_m (b & cfg.mask),
        .cut (cfg.cut),
        .raw (raw)
    );

    carry_tap u_tap (
        .raw        (raw),
        .lane_start (cfg.lane_start),
        .field_w    (cfg.field_w),
        .cout       (cout)
    );

    always_comb begin
        res_d      = '0;
        res_d.sum  = raw & cfg.mask;
        res_d.cout = cout;
    end

    assign sum       = res_d.sum;
    assign carry_out = res_d.cout;
endmodule

// File: rtl/simd_blank_adder_chk.sv
module simd_blank_adder_chk (
    input logic [1:0]  mode,
    input logic [31:0] a,
    input logic [31:0] b,
    input logic [31:0] sum,
    input logic [3:0]  carry_out
);
    logic [31:0] pad_keep;
    logic [3:0]  lane_used;
    logic [31:0] ref_sum;

    always_comb begin
        int nl;
        int cw;
        int fw;
        longint fa;
        longint fb;
        longint fm;
        case (mode)
            2'b01:   begin nl = 2; cw = 16; fw = 11; end
            2'b10:   begin nl = 4; cw = 8;  fw = 5;  end
            default: begin nl = 1; cw = 32; fw = 11; end
        endcase
        pad_keep  = '0;
        ref_sum   = '0;
        lane_used = '0;
        fm = (64'd1 << fw) - 1;
        for (int n = 0; n < nl; n++) begin
            fa = (longint'(a) >> (n*cw)) & fm;
            fb = (longint'(b) >> (n*cw)) & fm;
            ref_sum   = ref_sum | 32'(((fa + fb) & fm) << (n*cw));
            pad_keep  = pad_keep | 32'(fm << (n*cw));
            lane_used[n] = 1'b1;
        end

        // R4
        pad_zero_chk: assert ((sum & ~pad_keep) == 32'd0)
            else $error("padding bit set in sum");
        // R6
        tap_unused_chk: assert ((carry_out & ~lane_used) == 4'd0)
            else $error("carry_out set for absent lane");
        // R1
        wide_lane_chk: assert (mode != 2'b00 || sum == ref_sum)
            else $error("single lane sum wrong");
        // R2
        half_lane_chk: assert (mode != 2'b01 || sum == ref_sum)
            else $error("two lane sum wrong");
        // R3
        byte_lane_chk: assert (mode != 2'b10 || sum == ref_sum)
            else $error("four lane sum wrong");
        // R7
        alt_mode_chk: assert (mode != 2'b11 || sum == ref_sum)
            else $error("mode 11 sum wrong");
    end
endmodule

bind simd_blank_adder simd_blank_adder_chk u_chk (
    .mode      (mode),
    .a         (a),
    .b         (b),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/simd_blank_adder_test.sv
module simd_blank_adder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] sum;
    logic [3:0]  carry_out;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    simd_blank_adder uut (
        .mode      (mode),
        .a         (a),
        .b         (b),
        .sum       (sum),
        .carry_out (carry_out)
    );

    function automatic void model(input logic [1:0] m, input logic [31:0] x, input logic [31:0] y,
                                  output logic [31:0] s, output logic [3:0] c,
                                  output logic [31:0] keep, output int nl);
        int cw;
        int fw;
        longint fm;
        longint t;
        case (m)
            2'b01:   begin nl = 2; cw = 16; fw = 11; end
            2'b10:   begin nl = 4; cw = 8;  fw = 5;  end
            default: begin nl = 1; cw = 32; fw = 11; end
        endcase
        s = '0; c = '0; keep = '0;
        fm = (64'd1 << fw) - 1;
        for (int n = 0; n < nl; n++) begin
            t = ((longint'(x) >> (n*cw)) & fm) + ((longint'(y) >> (n*cw)) & fm);
            s = s | 32'((t & fm) << (n*cw));
            c[n] = t[fw];
            keep = keep | 32'(fm << (n*cw));
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        mode = m; a = x; b = y;
        @(posedge clk);
        #1;
    endtask

    task automatic run_vec(input logic [1:0] m, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] es;
        logic [31:0] keep;
        logic [3:0]  ec;
        int nl;
        string tag;
        drive(m, x, y);
        model(m, x, y, es, ec, keep, nl);
        case (m)
            2'b00:   tag = "R1";
            2'b01:   tag = "R2";
            2'b10:   tag = "R3";
            default: tag = "R7";
        endcase
        check(sum == es, tag, sum, es);
        check(carry_out == ec, "R5", {28'd0, carry_out}, {28'd0, ec});
        check((sum & ~keep) == 32'd0, "R4", sum & ~keep, 32'd0);
        check((carry_out >> nl) == 4'd0, "R6", {28'd0, carry_out}, {28'd0, ec});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] s0;
        logic [3:0]  c0;
        mode = 2'b00; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // R4 idle state: zero operands give zero outputs
        check(sum == 32'd0 && carry_out == 4'd0, "R4", sum, 32'd0);

        for (int m = 0; m < 4; m++) begin
            // R9: all ones in every lane, carries must stay inside lanes
            run_vec(2'(m), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            case (m)
                1:       check(sum == 32'h07FE_07FE && carry_out == 4'b0011, "R9", sum, 32'h07FE_07FE);
                2:       check(sum == 32'h1E1E_1E1E && carry_out == 4'b1111, "R9", sum, 32'h1E1E_1E1E);
                default: check(sum == 32'h0000_07FE && carry_out == 4'b0001, "R9", sum, 32'h0000_07FE);
            endcase
            for (int i = 0; i < 1024; i++) begin
                x = $urandom;
                y = $urandom;
                for (int n = 0; n < 4; n++) begin
                    x[8*n +: 5] = 5'(i + 7*n);
                    y[8*n +: 5] = 5'((i >> 5) + 3*n);
                end
                if (i[3:0] == 4'd0) begin
                    x[10:0]  = 11'h7FF; y[10:0]  = 11'(i >> 4);
                    x[26:16] = 11'h7FF; y[26:16] = 11'(i);
                end
                run_vec(2'(m), x, y);
            end
        end

        // R8: flipping only padding bits leaves outputs unchanged
        for (int m = 0; m < 3; m++) begin
            for (int i = 0; i < 64; i++) begin
                logic [31:0] keep;
                logic [31:0] es;
                logic [3:0]  ec;
                int nl;
                x = $urandom; y = $urandom;
                model(2'(m), x, y, es, ec, keep, nl);
                drive(2'(m), x, y);
                s0 = sum; c0 = carry_out;
                drive(2'(m), x ^ ~keep, y ^ ~keep);
                check(sum == s0 && carry_out == c0, "R8", sum, s0);
            end
        end

        // R7: mode 11 matches mode 00 on identical operands
        for (int i = 0; i < 64; i++) begin
            x = $urandom; y = $urandom;
            drive(2'b00, x, y);
            s0 = sum; c0 = carry_out;
            drive(2'b11, x, y);
            check(sum == s0 && carry_out == c0, "R7", sum, s0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule